// File: doc/BRIEF.md
# Phase-Difference Frequency Discriminator

This block converts a stream of phase samples, produced by a Cartesian-to-polar stage, into instantaneous frequency. It holds recent phase samples in a short delay line and subtracts the sample taken D samples earlier from the newest one. The result is the comb response 1 - z^-D. The difference wraps modulo one full turn, so a phase rollover between samples gives the correct small step and not a jump across full scale. The difference can then be multiplied by 1, 2, 4 or 8. The scaled value saturates into an 18-bit signed output.

A two-bit source select can route the block around the comb. In that case it passes an 18-bit magnitude word or an 18-bit in-phase word unchanged to the downstream filter, and it uses the data-ready strobe that matches that source. A separate control bit forces the Q word that feeds the coordinate converter to zero. The converter then reports the magnitude of I only.

Top module: `freq_disc`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `disc_vld` is 0, `disc_out` is 0 and `q_conv` is 0. Every delay-line entry starts at zero, so the first phase samples are differenced against zero.
- R2: With `src_sel` = 00, each `phase_vld` sample produces `disc_out` = phase_in(n) - phase_in(n-D), where D = `dly_sel` + 1 (1 to 8) and phase_in(n-D) is the sample D strobes earlier.
- R3: The delay line advances only on cycles where `phase_vld` is high, whatever `src_sel` is. Idle cycles between strobes do not age the stored samples.
- R4: `phase_in` is an unsigned 16-bit fraction of a turn. The difference is taken modulo 2^16 and read as two's complement. For example, 30 following 65500 gives +66.
- R5: `mult_sel` = k multiplies the signed difference by 2^k (k = 0..3). With k = 0 the output is the 16-bit difference sign-extended to 18 bits.
- R6: A scaled value above 131071 is output as 131071 (18'h1FFFF). A value below -131072 is output as -131072 (18'h20000).
- R7: On a cycle where `dly_sel` differs from its value on the previous cycle, every stored sample is cleared to zero. A strobe in that same cycle is differenced against zero.
- R8: With `src_sel` = 01, `disc_out` equals `mag_in`, unchanged, for each `phase_vld` strobe.
- R9: With `src_sel` = 10 or 11, `disc_out` equals `i_in`, unchanged, for each `i_vld` strobe. `phase_vld` produces no output in this mode.
- R10: `disc_vld` is the selected strobe (`i_vld` when `src_sel[1]` is 1, otherwise `phase_vld`) delayed by exactly 2 clock cycles. `disc_out` holds its value while `disc_vld` is low.
- R11: One cycle after the clock edge, `q_conv` shows 0 if `q_zero` was high at that edge, and shows `q_in` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dly_sel | input | 3 | Comb delay minus one (D = dly_sel + 1) |
| mult_sel | input | 2 | Phase multiplier exponent k (gain 2^k) |
| src_sel | input | 2 | Source: 00 phase difference, 01 magnitude, 1x in-phase |
| q_zero | input | 1 | Force the Q word to the converter to zero |
| phase_in | input | 16 | Phase sample, unsigned fraction of a turn |
| phase_vld | input | 1 | Converter data-ready strobe (phase and magnitude) |
| mag_in | input | 18 | Magnitude word from the converter |
| i_in | input | 18 | In-phase word from the resampler path |
| i_vld | input | 1 | Resampler data-ready strobe |
| q_in | input | 18 | Q word headed to the converter |
| q_conv | output | 18 | Q word to the converter, registered |
| disc_out | output | 18 | Filter input word, registered |
| disc_vld | output | 1 | Filter input strobe |

## Verification
The comb is driven with slowly rising phase ramps at D = 1 and D = 4. These separate a correct tap choice from a neighbouring one, and strobe gaps show whether idle cycles age the line. Sequences that cross the turn boundary in both directions separate modulo wrap from plain subtraction. Large steps under every multiplier separate shifting from saturation. A change of delay with a full line shows whether stale samples survive. Magnitude and in-phase words with distinctive bit patterns, sent alongside phase strobes that must be ignored, show which source and strobe reach the output. A phase difference taken after leaving in-phase mode shows that the line kept advancing there.

// File: rtl/fd_pkg.sv
package fd_pkg;
  typedef enum logic [1:0] {
    SRC_PHASE   = 2'b00,
    SRC_MAG     = 2'b01,
    SRC_INP     = 2'b10,
    SRC_INP_ALT = 2'b11
  } src_e;

  // in-phase source owns the resampler strobe
  function automatic logic src_uses_inphase(input logic [1:0] s);
    return s[1];
  endfunction
endpackage

// File: rtl/fd_delay_line.sv
module fd_delay_line #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int SEL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic [W-1:0]     din,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     tap
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (clr) begin
      for (int k = 1; k < DEPTH; k++) mem[k] <= '0;
      mem[0] <= adv ? din : '0;
    end else if (adv) begin
      mem[0] <= din;
      for (int k = 1; k < DEPTH; k++) mem[k] <= mem[k-1];
    end
  end

  // entry sel holds the sample sel+1 strobes back; a clear reads as zero
  assign tap = clr ? '0 : mem[sel];
endmodule

// File: rtl/fd_scale_sat.sv
module fd_scale_sat #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 18,
  parameter int SH_W  = 2
) (
  input  logic [IN_W-1:0]  din,
  input  logic [SH_W-1:0]  sh,
  output logic [OUT_W-1:0] dout
);
  localparam int MAX_SH = (1 << SH_W) - 1;
  localparam int EXT_W  = IN_W + MAX_SH;

  logic [EXT_W-1:0] wide;
  assign wide = {{MAX_SH{din[IN_W-1]}}, din} << sh;

  generate
    if (EXT_W > OUT_W) begin : g_clip
      localparam int HI_W = EXT_W - OUT_W + 1;
      logic [HI_W-1:0] hi_bits;
      logic            fits;
      assign hi_bits = wide[EXT_W-1:OUT_W-1];
      assign fits    = (hi_bits == '0) || (hi_bits == '1);
      always_comb begin
        if (fits)               dout = wide[OUT_W-1:0];
        else if (wide[EXT_W-1]) dout = {1'b1, {(OUT_W-1){1'b0}}};
        else                    dout = {1'b0, {(OUT_W-1){1'b1}}};
      end
    end else if (EXT_W == OUT_W) begin : g_same
      assign dout = wide;
    end else begin : g_ext
      assign dout = {{(OUT_W-EXT_W){wide[EXT_W-1]}}, wide};
    end
  endgenerate
endmodule

// File: rtl/freq_disc.sv
module freq_disc #(
  parameter int PH_W    = 16,
  parameter int OUT_W   = 18,
  parameter int MAX_DLY = 8,
  parameter int MULT_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(MAX_DLY)-1:0] dly_sel,
  input  logic [MULT_W-1:0]          mult_sel,
  input  logic [1:0]                 src_sel,
  input  logic                       q_zero,
  input  logic [PH_W-1:0]            phase_in,
  input  logic                       phase_vld,
  input  logic [OUT_W-1:0]           mag_in,
  input  logic [OUT_W-1:0]           i_in,
  input  logic                       i_vld,
  input  logic [OUT_W-1:0]           q_in,
  output logic [OUT_W-1:0]           q_conv,
  output logic [OUT_W-1:0]           disc_out,
  output logic                       disc_vld
);
  import fd_pkg::*;

  localparam int DLY_W = $clog2(MAX_DLY);

  logic [DLY_W-1:0] dly_q;
  logic             dly_chg;
  logic [PH_W-1:0]  tap;
  logic [PH_W-1:0]  diff_w;
  logic             sel_stb;

  assign dly_chg = (dly_sel != dly_q);
  assign sel_stb = src_uses_inphase(src_sel) ? i_vld : phase_vld;

  always_ff @(posedge clk) begin
    if (rst) dly_q <= '0;
    else     dly_q <= dly_sel;
  end

  fd_delay_line #(.W(PH_W), .DEPTH(MAX_DLY), .SEL_W(DLY_W)) u_dline (
    .clk (clk),
    .rst (rst),
    .clr (dly_chg),
    .adv (phase_vld),
    .din (phase_in),
    .sel (dly_sel),
    .tap (tap)
  );

  // modulo-turn difference: natural wrap of the unsigned subtract
  assign diff_w = phase_in - tap;

  // stage 1
  logic              s1_vld;
  src_e              s1_src;
  logic [PH_W-1:0]   s1_diff;
  logic [OUT_W-1:0]  s1_byp;
  logic [MULT_W-1:0] s1_mult;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_src  <= SRC_PHASE;
      s1_diff <= '0;
      s1_byp  <= '0;
      s1_mult <= '0;
    end else begin
      s1_vld  <= sel_stb;
      s1_src  <= src_e'(src_sel);
      s1_diff <= diff_w;
      s1_byp  <= src_uses_inphase(src_sel) ? i_in : mag_in;
      s1_mult <= mult_sel;
    end
  end

  logic [OUT_W-1:0] scaled;

  fd_scale_sat #(.IN_W(PH_W), .OUT_W(OUT_W), .SH_W(MULT_W)) u_scale (
    .din  (s1_diff),
    .sh   (s1_mult),
    .dout (scaled)
  );

  // stage 2: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      disc_vld <= 1'b0;
      disc_out <= '0;
      q_conv   <= '0;
    end else begin
      disc_vld <= s1_vld;
      if (s1_vld) disc_out <= (s1_src == SRC_PHASE) ? scaled : s1_byp;
      q_conv <= q_zero ? '0 : q_in;
    end
  end
endmodule

// File: rtl/fd_chk.sv
module fd_chk #(
  parameter int PH_W    = 16,
  parameter int OUT_W   = 18,
  parameter int MAX_DLY = 8,
  parameter int MULT_W  = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic [$clog2(MAX_DLY)-1:0] dly_sel,
  input logic [MULT_W-1:0]          mult_sel,
  input logic [1:0]                 src_sel,
  input logic                       q_zero,
  input logic [PH_W-1:0]            phase_in,
  input logic                       phase_vld,
  input logic [OUT_W-1:0]           mag_in,
  input logic [OUT_W-1:0]           i_in,
  input logic                       i_vld,
  input logic [OUT_W-1:0]           q_in,
  input logic [OUT_W-1:0]           q_conv,
  input logic [OUT_W-1:0]           disc_out,
  input logic                       disc_vld
);
  localparam int HI_W = OUT_W - PH_W + 1;

  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst)             cyc <= '0;
    else if (cyc != 2'd2) cyc <= cyc + 2'd1;
  end

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd2) |-> (disc_vld == $past(src_sel[1] ? i_vld : phase_vld, 2))); // R10

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cyc != 2'd0 && !disc_vld) |-> $stable(disc_out)); // R10

  AST_MAG_PASS: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd2 && disc_vld && $past(src_sel, 2) == 2'b01) |-> (disc_out == $past(mag_in, 2))); // R8

  AST_INP_PASS: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd2 && disc_vld && $past(src_sel[1], 2)) |-> (disc_out == $past(i_in, 2))); // R9

  AST_UNITY_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd2 && disc_vld && $past(src_sel, 2) == 2'b00 && $past(mult_sel, 2) == '0)
    |-> ($countones(disc_out[OUT_W-1:PH_W-1]) == 0 || $countones(disc_out[OUT_W-1:PH_W-1]) == HI_W)); // R5

  AST_Q_ZERO: assert property (@(posedge clk) disable iff (rst)
    q_zero |=> (q_conv == '0)); // R11

  AST_Q_PASS: assert property (@(posedge clk) disable iff (rst)
    !q_zero |=> (q_conv == $past(q_in))); // R11
endmodule

bind freq_disc fd_chk #(.PH_W(PH_W), .OUT_W(OUT_W), .MAX_DLY(MAX_DLY), .MULT_W(MULT_W)) u_chk (.*);

// File: tb/sim_freq_disc.sv
module sim_freq_disc;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  dly_sel = '0;
  logic [1:0]  mult_sel = '0;
  logic [1:0]  src_sel = '0;
  logic        q_zero = 1'b0;
  logic [15:0] phase_in = '0;
  logic        phase_vld = 1'b0;
  logic [17:0] mag_in = '0;
  logic [17:0] i_in = '0;
  logic        i_vld = 1'b0;
  logic [17:0] q_in = '0;
  logic [17:0] q_conv;
  logic [17:0] disc_out;
  logic        disc_vld;

  always #(CLK_P/2) clk = ~clk;

  freq_disc u0 (
    .clk(clk), .rst(rst), .dly_sel(dly_sel), .mult_sel(mult_sel), .src_sel(src_sel),
    .q_zero(q_zero), .phase_in(phase_in), .phase_vld(phase_vld), .mag_in(mag_in),
    .i_in(i_in), .i_vld(i_vld), .q_in(q_in), .q_conv(q_conv),
    .disc_out(disc_out), .disc_vld(disc_vld)
  );

  int tests = 0;
  int fails = 0;
  logic [17:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] hist [8];
  int          cur_d = 1;
  bit          mon_on = 1'b0;
  bit          done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] exp_phase(input logic [15:0] nw, input logic [15:0] od, input int k);
    logic [15:0] d;
    int v;
    d = nw - od;
    v = int'($signed(d)) * (1 << k);
    if (v > 131071) v = 131071;
    if (v < -131072) v = -131072;
    return v[17:0];
  endfunction

  task automatic push_hist(input logic [15:0] ph);
    for (int j = 7; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = ph;
  endtask

  task automatic cfg(input int d, input int k, input logic [1:0] s);
    @(negedge clk);
    phase_vld = 1'b0; i_vld = 1'b0;
    if (d != cur_d) for (int j = 0; j < 8; j++) hist[j] = '0;
    cur_d = d;
    dly_sel = 3'(d - 1); mult_sel = 2'(k); src_sel = s;
  endtask

  task automatic send_phase(input logic [15:0] ph, input string tag);
    @(negedge clk);
    phase_in = ph; phase_vld = 1'b1; i_vld = 1'b0; mag_in = '0;
    if (src_sel == 2'b00) begin
      exp_q.push_back(exp_phase(ph, hist[cur_d-1], int'(mult_sel)));
      tag_q.push_back(tag);
    end else if (src_sel == 2'b01) begin
      exp_q.push_back(18'h0);
      tag_q.push_back(tag);
    end
    push_hist(ph);
  endtask

  task automatic send_mag(input logic [17:0] m);
    @(negedge clk);
    phase_in = 16'h0; phase_vld = 1'b1; i_vld = 1'b0; mag_in = m;
    exp_q.push_back(m); tag_q.push_back("R8 magnitude");
    push_hist(16'h0);
  endtask

  task automatic send_inp(input logic [17:0] x);
    @(negedge clk);
    phase_vld = 1'b0; i_vld = 1'b1; i_in = x;
    if (src_sel[1]) begin
      exp_q.push_back(x); tag_q.push_back("R9 in-phase");
    end
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      phase_vld = 1'b0; i_vld = 1'b0;
    end
  endtask

  // monitor: compare outputs against the scoreboard
  always @(negedge clk) begin
    if (mon_on && !rst && disc_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 spurious output", disc_out, 18'h0);
      end else begin
        logic [17:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(disc_out == e, t, disc_out, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [17:0] held;
    for (int j = 0; j < 8; j++) hist[j] = '0;
    repeat (3) @(negedge clk);
    check(disc_vld == 1'b0, "R1 vld in reset", 18'(disc_vld), 18'h0);
    check(disc_out == '0, "R1 out in reset", disc_out, 18'h0);
    rst = 1'b0;
    @(negedge clk);
    check(disc_vld == 1'b0, "R1 vld after reset", 18'(disc_vld), 18'h0);
    check(disc_out == '0, "R1 out after reset", disc_out, 18'h0);
    check(q_conv == '0, "R1 q after reset", q_conv, 18'h0);
    mon_on = 1'b1;

    // R1 R2: D=1 ramp, first sample against zeroed line
    cfg(1, 0, 2'b00);
    send_phase(16'd100, "R1 R2 first vs zero");
    send_phase(16'd300, "R2 D1");
    send_phase(16'd250, "R2 D1 negative");
    send_phase(16'd1000, "R2 D1");
    idle(3);

    // R7 R3: D=4, change clears, gaps do not age
    cfg(4, 0, 2'b00);
    send_phase(16'd5000, "R7 cleared");
    send_phase(16'd6000, "R7 cleared");
    send_phase(16'd7000, "R7 cleared");
    send_phase(16'd8000, "R7 cleared");
    send_phase(16'd9000, "R2 D4");
    idle(2);
    send_phase(16'd11000, "R3 gap");
    idle(4);
    send_phase(16'd12500, "R3 gap");
    idle(3);

    // R4: wrap both ways
    cfg(1, 0, 2'b00);
    send_phase(16'd65500, "R4 setup");
    send_phase(16'd30, "R4 wrap up");
    send_phase(16'd10, "R4 small negative");
    send_phase(16'd40000, "R4 wrap down");
    idle(3);

    // R5: multipliers
    cfg(1, 1, 2'b00);
    send_phase(16'd1000, "R5 x2");
    send_phase(16'd1100, "R5 x2");
    cfg(1, 2, 2'b00);
    send_phase(16'd1300, "R5 x4");
    cfg(1, 3, 2'b00);
    send_phase(16'd1200, "R5 x8 negative");
    // R6: saturation
    send_phase(16'd0, "R6 setup");
    send_phase(16'd20000, "R6 saturate high");
    send_phase(16'd0, "R6 saturate low");
    send_phase(16'd100, "R5 x8 in range");
    idle(3);

    // R8: magnitude bypass
    cfg(1, 3, 2'b01);
    send_mag(18'h2ABCD);
    send_mag(18'h3FFFF);
    send_mag(18'h00005);
    idle(3);

    // R9: in-phase bypass, phase strobes ignored but still advance the line
    cfg(1, 0, 2'b10);
    send_inp(18'h12345);
    send_phase(16'd777, "R9 ignored");
    idle(2);
    send_inp(18'h00001);
    cfg(1, 0, 2'b11);
    send_inp(18'h3A5A5);
    idle(3);
    cfg(1, 0, 2'b00);
    send_phase(16'd800, "R3 advanced in bypass");
    idle(3);

    // R10: exact latency and hold
    send_phase(16'd900, "R10 value");
    @(negedge clk);
    phase_vld = 1'b0;
    check(disc_vld == 1'b0, "R10 not early", 18'(disc_vld), 18'h0);
    @(negedge clk);
    check(disc_vld == 1'b1, "R10 at latency", 18'(disc_vld), 18'h1);
    held = disc_out;
    @(negedge clk);
    check(disc_vld == 1'b0, "R10 single pulse", 18'(disc_vld), 18'h0);
    check(disc_out == held, "R10 hold", disc_out, held);

    // R11: Q zeroing
    @(negedge clk);
    q_in = 18'h15A5A; q_zero = 1'b0;
    @(negedge clk);
    check(q_conv == 18'h15A5A, "R11 pass", q_conv, 18'h15A5A);
    q_zero = 1'b1;
    @(negedge clk);
    check(q_conv == '0, "R11 zeroed", q_conv, 18'h0);
    q_zero = 1'b0;

    idle(4);
    check(exp_q.size() == 0, "R10 missing outputs", 18'(exp_q.size()), 18'h0);
    finish_run();
  end
endmodule